// File: doc/BRIEF.md
# Serial EEPROM Write-Protection Controller

This block holds the command and status state of a serial EEPROM. An upstream instruction decoder hands it one-cycle strobes for write enable, write disable, status read, status write and array write, together with an 8-bit status-write byte and a 15-bit array address. The block keeps the write-enable latch, three nonvolatile protection bits and a busy flag. It answers every array write with a one-cycle grant or deny pulse, and it always presents the status byte.

An accepted status write or array write starts an internal write cycle. A cycle counter of `T_WC` clock cycles models that cycle. While the cycle runs, the status byte reads as all ones. New protection bits take effect only when their write cycle completes. The level field selects whether none, the top quarter, the top half or the whole array is read-only. A status read strobe returns a registered copy of the status byte on `rd_data` with `rd_valid` one cycle later. There is no back-pressure: the decoder drives strobes as plain control pins, and `rd_valid` is a pulse that the consumer must take when it appears.

Top module: `eewp_ctrl`

## Requirements
- R1: After reset the status byte is 0x00, and `grant`, `deny` and `rd_valid` are low.
- R2: While idle, `cmd_wren` sets the write-enable latch (status bit 1 reads 1 on the next cycle). `cmd_wrdi` clears it on the next cycle.
- R3: When idle, the status byte is {bit7 = protect-enable flag, bits 6..4 = 0, bits 3..2 = level, bit 1 = write-enable latch, bit 0 = 0}. Bits 6..4 read 0 even when a status write carried ones there.
- R4: After an accepted status write or array write, the status byte reads 0xFF for exactly `T_WC` cycles, starting in the cycle after the strobe.
- R5: `cmd_rdsr` produces `rd_valid` high for one cycle on the next cycle, with `rd_data` equal to the status byte of the strobe cycle. This is honoured during a write cycle as well.
- R6: When a write cycle ends, the busy flag drops and the write-enable latch is clear.
- R7: A status write is accepted only when idle with the latch set. It stores byte bits 7, 3 and 2, and those bits become visible only when its write cycle completes. A refused status write leaves the stored bits unchanged and starts no cycle.
- R8: An array write with the write-enable latch clear is denied and starts no write cycle.
- R9: With level = 2'b00 no address is protected. 2'b01 protects 0x6000–0x7FFF, 2'b10 protects 0x4000–0x7FFF, and 2'b11 protects 0x0000–0x7FFF. An array write to a protected address is denied.
- R10: During a write cycle, write-enable, status-write and array-write strobes have no effect on state, and an array write is denied.
- R11: Each array-write strobe gives exactly one one-cycle pulse on either `grant` or `deny`, in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wren | input | 1 | Write-enable instruction strobe |
| cmd_wrdi | input | 1 | Write-disable instruction strobe |
| cmd_rdsr | input | 1 | Status-read instruction strobe |
| cmd_wrsr | input | 1 | Status-write instruction strobe |
| wrsr_data | input | 8 | Byte carried by the status write |
| cmd_write | input | 1 | Array-write request strobe |
| wr_addr | input | 15 | Array address of the write request |
| status | output | 8 | Live status byte |
| rd_valid | output | 1 | Status-read result valid pulse |
| rd_data | output | 8 | Status-read result |
| grant | output | 1 | Array write granted (pulse) |
| deny | output | 1 | Array write refused (pulse) |

## Verification
The assertions assume that the decoder raises at most one instruction strobe per cycle and that each strobe lasts a single cycle. A checker assertion in the top module guards this assumption. The bench drives every command through one task that raises a single strobe for one cycle and then clears it, so no two strobes ever overlap. Address and status-write data are held stable across the strobe cycle, as a real decoder would hold them.

// File: rtl/eewp_pkg.sv
package eewp_pkg;
  typedef struct packed {
    logic       wpen;
    logic [1:0] lvl;
  } prot_t;

  localparam logic [7:0] STAT_BUSY = 8'hFF;

  function automatic logic [7:0] pack_status(prot_t p, logic wen);
    return {p.wpen, 3'b000, p.lvl, wen, 1'b0};
  endfunction
endpackage

// File: rtl/eewp_timer.sv
module eewp_timer #(
  parameter int T_WC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (T_WC > 1) ? $clog2(T_WC) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(T_WC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // The caller must never restart a running cycle (R4)
  assert_start_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
endmodule

// File: rtl/eewp_wel.sv
module eewp_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic done,
  output logic wen
);
  logic wen_q;
  assign wen = wen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           wen_q <= 1'b0;
    else if (clr || done) wen_q <= 1'b0;
    else if (set)         wen_q <= 1'b1;
  end
endmodule

// File: rtl/eewp_prot.sv
module eewp_prot
  import eewp_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  prot_t             load_val,
  input  logic              done,
  input  logic [ADDR_W-1:0] addr,
  output prot_t             cur,
  output logic              hit
);
  prot_t cur_q, pend_q;
  logic  pend_vld_q;

  assign cur = cur_q;

  always_comb begin
    unique case (cur_q.lvl)
      2'b00: hit = 1'b0;
      2'b01: hit = &addr[ADDR_W-1 -: 2];
      2'b10: hit = addr[ADDR_W-1];
      default: hit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q      <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
    end else if (load) begin
      pend_q     <= load_val;
      pend_vld_q <= 1'b1;
    end else if (done && pend_vld_q) begin
      cur_q      <= pend_q;
      pend_vld_q <= 1'b0;
    end
  end

  // Stored bits change only at the end of a write cycle (R7)
  assert_bits_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pend_vld_q) |-> $stable(cur_q));
endmodule

// File: rtl/eewp_ctrl.sv
module eewp_ctrl
  import eewp_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int T_WC   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_rdsr,
  input  logic              cmd_wrsr,
  input  logic [7:0]        wrsr_data,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        status,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              grant,
  output logic              deny
);
  logic  busy, done, wen, hit;
  logic  acc_wren, acc_wrsr, acc_write;
  prot_t cur, new_bits;
  logic  grant_q, deny_q, rd_valid_q;
  logic [7:0] rd_data_q;
  logic  unused_bits;

  assign unused_bits = ^{wrsr_data[6:4], wrsr_data[1:0]};
  assign new_bits    = '{wpen: wrsr_data[7], lvl: wrsr_data[3:2]};

  assign acc_wren  = cmd_wren  && !busy;
  assign acc_wrsr  = cmd_wrsr  && !busy && wen;
  assign acc_write = cmd_write && !busy && wen && !hit;

  eewp_timer #(.T_WC(T_WC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(acc_wrsr || acc_write),
    .busy(busy), .done(done));

  eewp_wel u_wel (
    .clk(clk), .rst_n(rst_n), .set(acc_wren), .clr(cmd_wrdi),
    .done(done), .wen(wen));

  eewp_prot #(.ADDR_W(ADDR_W)) u_prot (
    .clk(clk), .rst_n(rst_n), .load(acc_wrsr), .load_val(new_bits),
    .done(done), .addr(wr_addr), .cur(cur), .hit(hit));

  assign status = busy ? STAT_BUSY : pack_status(cur, wen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q    <= 1'b0;
      deny_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      grant_q    <= acc_write;
      deny_q     <= cmd_write && !acc_write;
      rd_valid_q <= cmd_rdsr;
      if (cmd_rdsr) rd_data_q <= status;
    end
  end

  assign grant    = grant_q;
  assign deny     = deny_q;
  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  // Input contract: one instruction strobe per cycle
  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_wren, cmd_wrdi, cmd_rdsr, cmd_wrsr, cmd_write}));

  assert_grant_deny_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny));

  assert_grant_needs_wen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> $past(wen) && !$past(busy));

  assert_grant_unprot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !$past(hit));

  assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && $past(cmd_write) |-> deny);

  assert_end_clears_wen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wen);
endmodule

// File: tb/tb_eewp_ctrl.sv
module tb_eewp_ctrl;
  localparam int T_WC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_rdsr = 0, cmd_wrsr = 0, cmd_write = 0;
  logic [7:0]  wrsr_data = '0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  status, rd_data;
  logic        rd_valid, grant, deny;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  eewp_ctrl #(.ADDR_W(15), .T_WC(T_WC)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_rdsr(cmd_rdsr), .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data),
    .cmd_write(cmd_write), .wr_addr(wr_addr), .status(status),
    .rd_valid(rd_valid), .rd_data(rd_data), .grant(grant), .deny(deny));

  // {level[1:0], addr[14:0], expect_grant}
  localparam logic [17:0] VEC [10] = '{
    {2'b00, 15'h7FFF, 1'b1},
    {2'b01, 15'h5FFF, 1'b1},
    {2'b01, 15'h6000, 1'b0},
    {2'b01, 15'h7FFF, 1'b0},
    {2'b10, 15'h3FFF, 1'b1},
    {2'b10, 15'h4000, 1'b0},
    {2'b10, 15'h5FFF, 1'b0},
    {2'b11, 15'h0000, 1'b0},
    {2'b11, 15'h7FFF, 1'b0},
    {2'b00, 15'h0000, 1'b1}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef enum int {C_WREN, C_WRDI, C_RDSR, C_WRSR, C_WRITE} cmd_e;

  task automatic do_cmd(cmd_e c, logic [7:0] d, logic [14:0] a);
    wrsr_data = d;
    wr_addr   = a;
    cmd_wren  = (c == C_WREN);
    cmd_wrdi  = (c == C_WRDI);
    cmd_rdsr  = (c == C_RDSR);
    cmd_wrsr  = (c == C_WRSR);
    cmd_write = (c == C_WRITE);
    @(negedge clk);
    {cmd_wren, cmd_wrdi, cmd_rdsr, cmd_wrsr, cmd_write} = '0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait_cyc(3);
    chk("R1 status", status, 8'h00);
    chk("R1 pulses", {5'b0, grant, deny, rd_valid}, 8'h00);
    rst_n = 1'b1;
    wait_cyc(1);
    chk("R1 status after release", status, 8'h00);

    do_cmd(C_WREN, 8'h00, '0);
    chk("R2 wren sets", status, 8'h02);
    do_cmd(C_WRDI, 8'h00, '0);
    chk("R2 wrdi clears", status, 8'h00);

    do_cmd(C_WRITE, 8'h00, 15'h0000);
    chk("R8 deny without wen", {6'b0, grant, deny}, 8'h01);
    chk("R8 no busy", status, 8'h00);
    wait_cyc(1);
    chk("R11 pulse one cycle", {6'b0, grant, deny}, 8'h00);

    do_cmd(C_WRSR, 8'h8C, '0);
    chk("R7 refused wrsr no busy", status, 8'h00);
    wait_cyc(T_WC + 1);
    chk("R7 refused wrsr bits kept", status, 8'h00);

    // Accepted status write at edge k; busy for T_WC cycles
    do_cmd(C_WREN, 8'h00, '0);
    do_cmd(C_WRSR, 8'hFC, '0);               // k+0.5
    chk("R4 busy reads all ones", status, 8'hFF);
    do_cmd(C_RDSR, 8'h00, '0);               // k+1.5
    chk("R5 rd_valid during busy", {7'b0, rd_valid}, 8'h01);
    chk("R5 rd_data during busy", rd_data, 8'hFF);
    do_cmd(C_WREN, 8'h00, '0);               // k+2.5
    do_cmd(C_WRITE, 8'h00, 15'h0000);        // k+3.5
    chk("R10 write denied while busy", {6'b0, grant, deny}, 8'h01);
    do_cmd(C_WRSR, 8'h00, '0);               // k+4.5
    wait_cyc(T_WC - 5);                      // k+7.5
    chk("R4 last busy cycle", status, 8'hFF);
    wait_cyc(1);                             // k+8.5
    chk("R3 R6 R7 R10 bits after cycle", status, 8'h8C);
    do_cmd(C_RDSR, 8'h00, '0);
    chk("R5 rd_data idle", rd_data, 8'h8C);
    wait_cyc(1);
    chk("R5 rd_valid single pulse", {7'b0, rd_valid}, 8'h00);

    do_cmd(C_WREN, 8'h00, '0);
    chk("R3 wen bit with bits", status, 8'h8E);
    do_cmd(C_WRDI, 8'h00, '0);

    foreach (VEC[i]) begin
      logic [1:0]  lvl;
      logic [14:0] adr;
      logic        exp_g;
      {lvl, adr, exp_g} = VEC[i];
      do_cmd(C_WREN, 8'h00, '0);
      do_cmd(C_WRSR, {4'b0000, lvl, 2'b00}, '0);
      wait_cyc(T_WC);
      chk("R7 level stored", status, {4'b0000, lvl, 2'b00});
      do_cmd(C_WREN, 8'h00, '0);
      do_cmd(C_WRITE, 8'h00, adr);
      chk("R9 R11 grant/deny", {6'b0, grant, deny}, {6'b0, exp_g, !exp_g});
      chk("R4 R9 busy only if granted", status,
          exp_g ? 8'hFF : {4'b0000, lvl, 2'b10});
      if (exp_g) begin
        wait_cyc(T_WC);
        chk("R6 wen clear after array write", status, {4'b0000, lvl, 2'b00});
      end else begin
        do_cmd(C_WRDI, 8'h00, '0);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule